// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of an integrating analog-to-digital converter. It drives three analog switch controls around an external integrator: one that shorts the integrator to clear it, one that feeds it the unknown input, and one that feeds it a reference of opposite polarity. The integrator, the switches and the zero-crossing comparator all sit outside the block. The block sees only the comparator output bit.

After an accepted start, the block runs four phases in turn:
- It clears the integrator for a fixed number of cycles.
- It integrates the input for a programmed number of cycles, the run-up length.
- It integrates the reference and counts clock cycles until the comparator reports that the integrator is back at zero.
- It reports that count as the conversion result, with a one-cycle done pulse.

A longer run-up gives a larger count for the same input, so it gives finer resolution at the cost of conversion time. A shorter run-up gives a faster, coarser conversion. If the integrator never returns to zero within twice the run-up length, the result is clamped and an overrange flag is set.

Top module: `dslope_adc_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters idle. In idle all three switch outputs are 0 and `busy`, `done`, `result` and `overrange` are 0.
- R2: A start is accepted when `start` is 1 at an edge while the block is idle and `runup_len` is non-zero. From the next cycle, `sw_zero` is 1 for exactly AZ_CYCLES cycles and `busy` is 1.
- R3: Right after the clear phase, `sw_input` is 1 for exactly the number of cycles that `runup_len` held at the accepting edge. Changes to `runup_len` after that edge have no effect on the conversion.
- R4: Right after run-up, `sw_ref` is 1 until the rundown ends. At most one of the three switch outputs is 1 in any cycle.
- R5: `cmp_in` is 1 while the integrator has not yet returned to zero and 0 once it has. It passes through a two-flop synchronizer. The result is K, the number of rundown cycles that complete before the first cycle in which `cmp_in` reads 0. The rundown phase lasts K+3 cycles, which compensates for the synchronizer latency.
- R6: The synchronized comparator is ignored during the first two rundown cycles, because those cycles still carry values from before rundown. An integrator that starts at zero yields result 0.
- R7: If K exceeds twice the run-up length L, the rundown lasts 2L+3 cycles, `result` is 2L and `overrange` is 1. If K equals 2L exactly, `overrange` stays 0.
- R8: `done` is 1 for exactly one cycle, the cycle right after the rundown ends. `result` and `overrange` take their new values in that cycle and hold them until the next accepted start, which clears both to 0 on the following cycle.
- R9: A start while `busy` is 1 is ignored. This includes a start during the done cycle.
- R10: A start with `runup_len` equal to 0 is ignored. The block stays idle and `result` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, sampled at each edge |
| runup_len | input | CNT_W | Run-up length in clock cycles |
| cmp_in | input | 1 | Asynchronous comparator bit, 1 while the integrator is not yet back at zero |
| sw_zero | output | 1 | Integrator clear switch control |
| sw_input | output | 1 | Unknown-input switch control |
| sw_ref | output | 1 | Reference switch control |
| busy | output | 1 | Conversion in progress, including the done cycle |
| done | output | 1 | One-cycle conversion complete pulse |
| result | output | CNT_W+1 | Rundown count |
| overrange | output | 1 | Rundown hit its 2L limit without a zero crossing |

## Verification
The hardest conditions to reach from the ports are the ones at the edges of the rundown window:
- a zero crossing inside the two cycles where the synchronizer still shows pre-rundown values;
- a crossing that lands exactly on the 2L limit rather than one count past it.

The bench reaches both with a behavioural integrator that adds the input value on each run-up cycle and subtracts the reference value on each rundown cycle. Choosing the ratio of the two sets K exactly: a zero input and a run-up of one cycle cover the masked window, and input-to-reference ratios of 2 and 3 cover the limit. Starts are also injected in the middle of run-up and during the done cycle, together with a changed `runup_len`, to show that neither reaches the running conversion.

// File: rtl/dslope_pkg.sv
// Shared types for the dual-slope converter sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package dslope_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_AZERO = 3'd1,
        ST_RUNUP = 3'd2,
        ST_RUNDN = 3'd3,
        ST_DONE  = 3'd4
    } dsl_state_e;
endpackage

// File: rtl/dslope_sync.sv
// Multi-flop synchronizer for the asynchronous comparator bit.
// Assumes: STAGES >= 2; the output lags the input by STAGES edges.
module dslope_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    // shift the raw bit through the chain of flops
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dslope_seq.sv
// Phase sequencer: clear, run-up, rundown and done, with the phase counter.
// Produces a capture strobe with the compensated count and the overrange
// decision, and a clear strobe when a start is accepted.
// Assumes: cmp_s is already synchronized with SYNC_STAGES flops of latency.
module dslope_seq
    import dslope_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int AZ_CYCLES   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int RES_W      = CNT_W + 1,
    localparam int PH_W       = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] runup_len,
    input  logic             cmp_s,
    output dsl_state_e       state_o,
    output logic [CNT_W-1:0] len_lat_o,
    output logic             clr_o,
    output logic             cap_o,
    output logic [RES_W-1:0] cap_val_o,
    output logic             cap_ovr_o
);
    dsl_state_e       state, state_nx;
    logic [PH_W-1:0]  ph_cnt;
    logic [CNT_W-1:0] len_lat;
    logic [RES_W-1:0] max_rd;
    logic [PH_W-1:0]  rd_limit;
    logic             start_ok, az_last, runup_last, rd_armed, rd_hit, rd_sat, rd_end;

    assign start_ok   = (state == ST_IDLE) && start && (runup_len != '0);
    assign az_last    = (ph_cnt == PH_W'(AZ_CYCLES - 1));
    assign runup_last = (ph_cnt == (PH_W'(len_lat) - PH_W'(1)));
    assign max_rd     = {len_lat, 1'b0};
    assign rd_limit   = PH_W'(max_rd) + PH_W'(SYNC_STAGES);
    assign rd_armed   = (ph_cnt >= PH_W'(SYNC_STAGES));
    assign rd_hit     = (state == ST_RUNDN) && rd_armed && !cmp_s;
    assign rd_sat     = (state == ST_RUNDN) && (ph_cnt == rd_limit) && cmp_s;
    assign rd_end     = rd_hit || rd_sat;

    // next-phase decision
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (start_ok)   state_nx = ST_AZERO;
            ST_AZERO: if (az_last)    state_nx = ST_RUNUP;
            ST_RUNUP: if (runup_last) state_nx = ST_RUNDN;
            ST_RUNDN: if (rd_end)     state_nx = ST_DONE;
            ST_DONE:                  state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // cycles spent in the current phase, zeroed on every phase change
    always_ff @(posedge clk) begin
        if (!rst_n)                 ph_cnt <= '0;
        else if (state_nx != state) ph_cnt <= '0;
        else if (state != ST_IDLE)  ph_cnt <= ph_cnt + PH_W'(1);
    end

    // run-up length frozen at the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n)        len_lat <= '0;
        else if (start_ok) len_lat <= runup_len;
    end

    assign state_o   = state;
    assign len_lat_o = len_lat;
    assign clr_o     = start_ok;
    assign cap_o     = rd_end;
    assign cap_ovr_o = !rd_hit;
    assign cap_val_o = rd_hit ? RES_W'(ph_cnt - PH_W'(SYNC_STAGES)) : max_rd;

    AST_START_TO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (state == ST_AZERO) && (ph_cnt == '0));                      // R2
    AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(len_lat));                                  // R3
    AST_MASK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUNDN && ph_cnt < PH_W'(SYNC_STAGES)) |=> (state == ST_RUNDN)); // R6
    AST_RD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUNDN) |-> (ph_cnt <= rd_limit));                             // R7
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE));                                // R9
    AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && runup_len == '0) |=> (state == ST_IDLE));             // R10
endmodule

// File: rtl/dslope_result.sv
// Result and overrange holding register.
// Cleared by an accepted start, loaded by the end-of-rundown capture strobe.
// Assumes: clr and cap never arrive in the same cycle.
module dslope_result #(
    parameter int RES_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cap,
    input  logic [RES_W-1:0] cap_val,
    input  logic             cap_ovr,
    output logic [RES_W-1:0] result,
    output logic             overrange
);
    // hold the last conversion outcome
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            result    <= '0;
            overrange <= 1'b0;
        end else if (cap) begin
            result    <= cap_val;
            overrange <= cap_ovr;
        end
    end

    AST_CLR_CAP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && cap));                                                          // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !cap) |=> ($stable(result) && $stable(overrange)));             // R8
endmodule

// File: rtl/dslope_adc_ctrl.sv
// Dual-slope integrating converter sequencer, top level.
// Drives the clear, input and reference switches of an external integrator.
// Times the rundown against the synchronized comparator.
// Assumes: cmp_in is asynchronous; runup_len is sampled only at an accepted start.
module dslope_adc_ctrl
    import dslope_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int AZ_CYCLES   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int RES_W      = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] runup_len,
    input  logic             cmp_in,
    output logic             sw_zero,
    output logic             sw_input,
    output logic             sw_ref,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             overrange
);
    dsl_state_e       state;
    logic [CNT_W-1:0] len_lat;
    logic             cmp_s, clr, cap, cap_ovr;
    logic [RES_W-1:0] cap_val;

    dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(cmp_in), .q(cmp_s)
    );

    dslope_seq #(.CNT_W(CNT_W), .AZ_CYCLES(AZ_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .runup_len(runup_len), .cmp_s(cmp_s),
        .state_o(state), .len_lat_o(len_lat), .clr_o(clr), .cap_o(cap),
        .cap_val_o(cap_val), .cap_ovr_o(cap_ovr)
    );

    dslope_result #(.RES_W(RES_W)) u_res (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cap(cap), .cap_val(cap_val),
        .cap_ovr(cap_ovr), .result(result), .overrange(overrange)
    );

    // switch and status decode from the registered phase
    always_comb begin
        sw_zero  = (state == ST_AZERO);
        sw_input = (state == ST_RUNUP);
        sw_ref   = (state == ST_RUNDN);
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
    end

    AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sw_zero, sw_input, sw_ref}) <= 1);                           // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                         // R8
    AST_OVR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        overrange |-> (result == {len_lat, 1'b0}));                              // R7
    AST_RESULT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result <= {len_lat, 1'b0}));                                   // R7
endmodule

// File: tb/dslope_adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module dslope_adc_ctrl_tb_top;
    localparam int CNT_W = 12;
    localparam int AZ    = 4;
    localparam int SYNC  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] runup_len = '0;
    logic             cmp_in = 1'b0;
    logic             sw_zero, sw_input, sw_ref, busy, done, overrange;
    logic [CNT_W:0]   result;

    dslope_adc_ctrl #(.CNT_W(CNT_W), .AZ_CYCLES(AZ), .SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .runup_len(runup_len), .cmp_in(cmp_in),
        .sw_zero(sw_zero), .sw_input(sw_input), .sw_ref(sw_ref), .busy(busy),
        .done(done), .result(result), .overrange(overrange)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int vin = 0, vref = 1, integ = 0;
    // reference model: 0 idle, 1 clear, 2 run-up, 3 rundown, 4 done
    int m_ph = 0, m_cnt = 0, m_len = 0, m_need = 0, e_res = 0, e_ovr = 0;
    bit model_live = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // behavioural integrator: comparator shows the level before this cycle's step
    always @(negedge clk) begin
        cmp_in = (integ > 0);
        if (sw_zero)       integ = 0;
        else if (sw_input) integ = integ + vin;
        else if (sw_ref)   integ = integ - vref;
    end

    // cycle model built from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; e_res = 0; e_ovr = 0; model_live = 1'b1;
        end else begin
            case (m_ph)
                0: if (start && runup_len != 0) begin
                       int k;
                       m_ph = 1; m_cnt = 0; m_len = int'(runup_len);
                       k = (m_len * vin + vref - 1) / vref;
                       m_need = (k > 2 * m_len) ? 2 * m_len : k;
                       e_ovr  = (k > 2 * m_len) ? 1 : 0;
                       e_res  = 0;
                   end
                1: begin m_cnt++; if (m_cnt == AZ) begin m_ph = 2; m_cnt = 0; end end
                2: begin m_cnt++; if (m_cnt == m_len) begin m_ph = 3; m_cnt = 0; end end
                3: begin
                       m_cnt++;
                       if (m_cnt == m_need + 3) begin m_ph = 4; e_res = m_need; end
                   end
                default: m_ph = 0;
            endcase
            if (m_ph != 4 && m_ph != 0) ; // phases continue
        end
    end

    // per-cycle comparison and watchdog
    always @(negedge clk) begin
        cyc++;
        if (model_live) begin
            chk("R2", "sw_zero",  int'(sw_zero),  int'(m_ph == 1));
            chk("R3", "sw_input", int'(sw_input), int'(m_ph == 2));
            chk("R4", "sw_ref",   int'(sw_ref),   int'(m_ph == 3));
            chk("R9", "busy",     int'(busy),     int'(m_ph != 0));
            chk("R8", "done",     int'(done),     int'(m_ph == 4));
            chk("R5", "result",   int'(result),   (m_ph == 4 || m_ph == 0) ? e_res : int'(result));
            chk("R7", "overrange", int'(overrange), (m_ph == 4 || m_ph == 0) ? e_ovr : int'(overrange));
        end
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            finish_up();
        end
    end

    task automatic conv(input int n, input int vi, input int vr, input string tag,
                        input bit disturb, input bit poke_done);
        int k, exp_r, exp_o;
        vin = vi; vref = vr; runup_len = CNT_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "result cleared", int'(result), 0);
        chk("R2", "clear switch on", int'(sw_zero), 1);
        k = (n * vi + vr - 1) / vr;
        exp_o = (k > 2 * n) ? 1 : 0;
        exp_r = exp_o ? 2 * n : k;
        if (disturb) begin
            repeat (AZ + 1) @(negedge clk);
            start = 1'b1; runup_len = CNT_W'(3);
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(tag, "result", int'(result), exp_r);
        chk(tag, "overrange", int'(overrange), exp_o);
        if (poke_done) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_done) chk("R9", "start in done cycle ignored", int'(busy), 0);
        chk("R8", "result held", int'(result), exp_r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset busy", int'(busy), 0);
        chk("R1", "reset switches", int'({sw_zero, sw_input, sw_ref}), 0);
        chk("R1", "reset done", int'(done), 0);
        chk("R1", "reset result", int'(result), 0);
        chk("R1", "reset overrange", int'(overrange), 0);
        rst_n = 1'b1;
        @(negedge clk);
        conv(10, 6, 10, "R5", 1'b0, 1'b0);     // K = 6
        conv(16, 5, 8, "R5", 1'b0, 1'b1);      // K = 10, start poked in done cycle
        conv(10, 0, 5, "R6", 1'b0, 1'b0);      // integrator starts at zero
        conv(1, 1, 1, "R6", 1'b0, 1'b0);       // K = 1 right after masked window
        conv(7, 2, 1, "R7", 1'b0, 1'b0);       // K = 14 = 2L, no overrange
        conv(7, 3, 1, "R7", 1'b0, 1'b0);       // K = 21 > 14, clamped
        conv(20, 3, 4, "R3", 1'b1, 1'b0);      // start and new length mid-run ignored
        conv(1000, 1, 1, "R3", 1'b0, 1'b0);    // long run-up, K = 1000
        // zero-length start ignored
        runup_len = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10", "zero length stays idle", int'(busy), 0);
        chk("R10", "zero length keeps result", int'(result), 1000);
        @(negedge clk);
        chk("R10", "zero length no clear phase", int'(sw_zero), 0);
        // back-to-back run after the ignored one
        conv(3, 4, 3, "R5", 1'b0, 1'b0);       // K = 4
        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule